// File: doc/BRIEF.md
# Four-Way Replacement Victim Selector

This block decides which line of a four-way set-associative cache is overwritten when a new line is brought in. For every set it holds one valid bit per way and three tree bits of pseudo-LRU history. When an allocation request names a set, the chosen way appears on the output in the same cycle. An empty way is used if the set has one, and the tree history decides only when the set is full.

Three update ports keep the state current. Hits and fills refresh the history, and fills also mark their line valid. Invalidations clear one line's valid bit and leave the history alone. A flush command clears every valid bit and every history bit in one cycle. The cache's tag compare and data arrays are outside this block and drive these ports.

Top module: `way_evict_picker`

## Requirements
- R1: While `alloc_req_i` is high, `victim_vld_o` is high and `victim_way_o` gives the chosen way (0 to 3) for set `alloc_set_i` in the same cycle. While `alloc_req_i` is low, both outputs read 0.
- R2: If any way of the requested set is not valid, the victim is the lowest-numbered such way, so way 0 is checked first and way 3 last.
- R3: If all four ways are valid, the tree bits choose the victim. The root bit selects the pair: 0 for ways {0,1} and 1 for ways {2,3}. The lower-pair bit then selects way 0 (0) or way 1 (1), and the upper-pair bit selects way 2 (0) or way 3 (1).
- R4: A hit on a way sets the bits on its path so they point away from it. For way 0 this is root=1 and lower=1. For way 1 it is root=1 and lower=0. For way 2 it is root=0 and upper=1. For way 3 it is root=0 and upper=0. The other pair's bit is unchanged.
- R5: A fill sets the valid bit of its set and way and updates the tree bits as in R4. When a hit and a fill reach the same set in one cycle, the hit is applied first and the fill's bits take precedence.
- R6: An invalidate clears the valid bit of one set and way and leaves the tree bits unchanged. It takes precedence over a fill to the same line in the same cycle.
- R7: A flush clears all valid bits and all tree bits of every set on the next clock edge. It overrides any hit, fill or invalidate in the same cycle.
- R8: Asserting `rst_n` low clears all valid and tree bits at once. Release is synchronised over two clock edges, and updates are ignored until release is complete.
- R9: An update changes only the set it addresses. The state of every other set is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all valid and tree bits |
| alloc_req_i | input | 1 | Allocation request |
| alloc_set_i | input | SET_W | Set index for the allocation |
| victim_way_o | output | 2 | Chosen way |
| victim_vld_o | output | 1 | Victim output is meaningful |
| hit_i | input | 1 | Hit update strobe |
| hit_set_i | input | SET_W | Set of the hit |
| hit_way_i | input | 2 | Way of the hit |
| fill_i | input | 1 | Fill update strobe |
| fill_set_i | input | SET_W | Set of the fill |
| fill_way_i | input | 2 | Way of the fill |
| inval_i | input | 1 | Single-line invalidate strobe |
| inval_set_i | input | SET_W | Set of the invalidate |
| inval_way_i | input | 2 | Way of the invalidate |

## Verification
Directed fill sequences grow a set from empty to full. This separates the free-way scan from the tree choice, and the order of fills fixes the expected root and pair bits. Hits on chosen ways of a full set show whether each pair bit points away from the touched way. Running a hit and a fill together in one cycle shows which update is applied last. Invalidates into a full set, fill-plus-invalidate on a single line, and a flush with pending updates show the precedence rules. Long random traffic on a few sets checks every cycle against a behavioural model, and an untouched set checks that sets stay independent.

// File: rtl/evict_pkg.sv
package evict_pkg;

  localparam int WAY_CNT = 4;
  localparam int WAY_W   = 2;

  typedef logic [WAY_W-1:0] way_idx_t;

  // root: 0 selects pair {0,1}, 1 selects pair {2,3}
  // lo:   0 selects way 0, 1 selects way 1
  // hi:   0 selects way 2, 1 selects way 3
  typedef struct packed {
    logic root;
    logic lo;
    logic hi;
  } plru_t;

  // Point the path of a touched way away from it.
  function automatic plru_t plru_touch(plru_t cur, way_idx_t w);
    plru_t nxt;
    nxt      = cur;
    nxt.root = ~w[1];
    if (!w[1]) nxt.lo = ~w[0];
    else       nxt.hi = ~w[0];
    return nxt;
  endfunction

endpackage

// File: rtl/evict_rst_sync.sv
module evict_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/evict_valid_bank.sv
module evict_valid_bank
  import evict_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               fill_en_i,
  input  logic [SET_W-1:0]   fill_set_i,
  input  way_idx_t           fill_way_i,
  input  logic               inv_en_i,
  input  logic [SET_W-1:0]   inv_set_i,
  input  way_idx_t           inv_way_i,
  input  logic [SET_W-1:0]   rd_set_i,
  output logic [WAY_CNT-1:0] rd_valid_o
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0][WAY_CNT-1:0] valid_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAY_CNT-1:0] valid_d;
    logic               hit_fill;
    logic               hit_inv;
    logic               upd_en;

    assign hit_fill = fill_en_i && (fill_set_i == SET_W'(s));
    assign hit_inv  = inv_en_i  && (inv_set_i  == SET_W'(s));
    assign upd_en   = flush_i || hit_fill || hit_inv;

    always_comb begin
      valid_d = valid_q[s];
      if (flush_i) begin
        valid_d = '0;
      end else begin
        if (hit_fill) valid_d[fill_way_i] = 1'b1;
        if (hit_inv)  valid_d[inv_way_i]  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q[s] <= '0;
      else if (upd_en) valid_q[s] <= valid_d;
    end
  end

  assign rd_valid_o = valid_q[rd_set_i];

endmodule

// File: rtl/evict_plru_bank.sv
module evict_plru_bank
  import evict_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             hit_en_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  way_idx_t         hit_way_i,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  way_idx_t         fill_way_i,
  input  logic [SET_W-1:0] rd_set_i,
  output plru_t            rd_tree_o
);

  localparam int SETS = 1 << SET_W;

  plru_t tree_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    plru_t tree_d;
    logic  sel_hit;
    logic  sel_fill;
    logic  upd_en;

    assign sel_hit  = hit_en_i  && (hit_set_i  == SET_W'(s));
    assign sel_fill = fill_en_i && (fill_set_i == SET_W'(s));
    assign upd_en   = flush_i || sel_hit || sel_fill;

    always_comb begin
      tree_d = tree_q[s];
      if (flush_i) begin
        tree_d = '0;
      end else begin
        if (sel_hit)  tree_d = plru_touch(tree_d, hit_way_i);
        if (sel_fill) tree_d = plru_touch(tree_d, fill_way_i);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tree_q[s] <= '0;
      else if (upd_en) tree_q[s] <= tree_d;
    end
  end

  assign rd_tree_o = tree_q[rd_set_i];

endmodule

// File: rtl/evict_way_pick.sv
module evict_way_pick
  import evict_pkg::*;
(
  input  logic [WAY_CNT-1:0] valid_i,
  input  plru_t              tree_i,
  output way_idx_t           way_o
);

  way_idx_t tree_way;

  always_comb begin
    if (!tree_i.root) tree_way = tree_i.lo ? 2'd1 : 2'd0;
    else              tree_way = tree_i.hi ? 2'd3 : 2'd2;
  end

  // Scan from the top down so the lowest free way is the last assignment.
  always_comb begin
    way_o = tree_way;
    for (int i = WAY_CNT - 1; i >= 0; i--) begin
      if (!valid_i[i]) way_o = way_idx_t'(i);
    end
  end

endmodule

// File: rtl/way_evict_picker.sv
module way_evict_picker
  import evict_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             alloc_req_i,
  input  logic [SET_W-1:0] alloc_set_i,
  output logic [1:0]       victim_way_o,
  output logic             victim_vld_o,
  input  logic             hit_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [1:0]       hit_way_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [1:0]       fill_way_i,
  input  logic             inval_i,
  input  logic [SET_W-1:0] inval_set_i,
  input  logic [1:0]       inval_way_i
);

  logic               rst_sync_n;
  logic [WAY_CNT-1:0] rd_valid;
  plru_t              rd_tree;
  way_idx_t           pick_way;

  evict_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evict_valid_bank #(.SET_W(SET_W)) u_valid (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush_i    (flush_i),
    .fill_en_i  (fill_i),
    .fill_set_i (fill_set_i),
    .fill_way_i (fill_way_i),
    .inv_en_i   (inval_i),
    .inv_set_i  (inval_set_i),
    .inv_way_i  (inval_way_i),
    .rd_set_i   (alloc_set_i),
    .rd_valid_o (rd_valid)
  );

  evict_plru_bank #(.SET_W(SET_W)) u_plru (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush_i    (flush_i),
    .hit_en_i   (hit_i),
    .hit_set_i  (hit_set_i),
    .hit_way_i  (hit_way_i),
    .fill_en_i  (fill_i),
    .fill_set_i (fill_set_i),
    .fill_way_i (fill_way_i),
    .rd_set_i   (alloc_set_i),
    .rd_tree_o  (rd_tree)
  );

  evict_way_pick u_pick (
    .valid_i (rd_valid),
    .tree_i  (rd_tree),
    .way_o   (pick_way)
  );

  assign victim_vld_o = alloc_req_i;
  assign victim_way_o = alloc_req_i ? pick_way : 2'd0;

endmodule

module way_evict_picker_chk
  import evict_pkg::*;
#(
  parameter int SET_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               alloc_req_i,
  input logic [SET_W-1:0]   alloc_set_i,
  input logic [1:0]         victim_way_o,
  input logic               hit_i,
  input logic [SET_W-1:0]   hit_set_i,
  input logic [1:0]         hit_way_i,
  input logic               fill_i,
  input logic [SET_W-1:0]   fill_set_i,
  input logic [1:0]         fill_way_i,
  input logic               inval_i,
  input logic [SET_W-1:0]   inval_set_i,
  input logic [1:0]         inval_way_i,
  input logic [WAY_CNT-1:0] rd_valid,
  input plru_t              rd_tree
);

  assert_free_way_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && rd_valid != 4'hF) |-> !rd_valid[victim_way_o]);

  assert_full_set_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && rd_valid == 4'hF) |-> (victim_way_o[1] == rd_tree.root));

  assert_hit_moves_away_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && hit_i && !flush_i && !fill_i) && alloc_req_i &&
     alloc_set_i == $past(hit_set_i) && rd_valid == 4'hF)
    |-> (victim_way_o != $past(hit_way_i)));

  assert_fill_not_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && fill_i && !flush_i &&
           !(inval_i && inval_set_i == fill_set_i && inval_way_i == fill_way_i)) &&
     alloc_req_i && alloc_set_i == $past(fill_set_i))
    |-> (victim_way_o != $past(fill_way_i)));

  assert_inval_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && inval_i && !flush_i) && alloc_req_i &&
     alloc_set_i == $past(inval_set_i))
    |-> (victim_way_o <= $past(inval_way_i)));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && flush_i) && alloc_req_i)
    |-> (victim_way_o == 2'd0 && rd_valid == '0 && rd_tree == '0));

endmodule

bind way_evict_picker way_evict_picker_chk #(.SET_W(SET_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .flush_i      (flush_i),
  .alloc_req_i  (alloc_req_i),
  .alloc_set_i  (alloc_set_i),
  .victim_way_o (victim_way_o),
  .hit_i        (hit_i),
  .hit_set_i    (hit_set_i),
  .hit_way_i    (hit_way_i),
  .fill_i       (fill_i),
  .fill_set_i   (fill_set_i),
  .fill_way_i   (fill_way_i),
  .inval_i      (inval_i),
  .inval_set_i  (inval_set_i),
  .inval_way_i  (inval_way_i),
  .rd_valid     (rd_valid),
  .rd_tree      (rd_tree)
);

// File: tb/way_evict_picker_test.sv
module way_evict_picker_test;

  localparam int SET_W = 4;
  localparam int SETS  = 1 << SET_W;

  logic             clk;
  logic             rst_n;
  logic             flush_i;
  logic             alloc_req_i;
  logic [SET_W-1:0] alloc_set_i;
  logic [1:0]       victim_way_o;
  logic             victim_vld_o;
  logic             hit_i;
  logic [SET_W-1:0] hit_set_i;
  logic [1:0]       hit_way_i;
  logic             fill_i;
  logic [SET_W-1:0] fill_set_i;
  logic [1:0]       fill_way_i;
  logic             inval_i;
  logic [SET_W-1:0] inval_set_i;
  logic [1:0]       inval_way_i;

  way_evict_picker #(.SET_W(SET_W)) uut (.*);

  int n_cmp;
  int n_bad;
  int live;
  int done;

  // behavioural reference state
  int mval  [SETS][4];
  int mroot [SETS];
  int mlo   [SETS];
  int mhi   [SETS];

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic int exp_victim(int s);
    for (int w = 0; w < 4; w++) if (mval[s][w] == 0) return w;
    if (mroot[s] == 0) return (mlo[s] != 0) ? 1 : 0;
    return (mhi[s] != 0) ? 3 : 2;
  endfunction

  task automatic touch(int s, int w);
    if (w < 2) begin mroot[s] = 1; mlo[s] = (w == 0) ? 1 : 0; end
    else       begin mroot[s] = 0; mhi[s] = (w == 2) ? 1 : 0; end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < 4; w++) mval[s][w] = 0;
      mroot[s] = 0; mlo[s] = 0; mhi[s] = 0;
    end
  endtask

  task automatic model_update();
    if (flush_i) begin
      model_clear();
    end else begin
      if (hit_i)   touch(int'(hit_set_i), int'(hit_way_i));
      if (fill_i) begin
        mval[fill_set_i][fill_way_i] = 1;
        touch(int'(fill_set_i), int'(fill_way_i));
      end
      if (inval_i) mval[inval_set_i][inval_way_i] = 0;
    end
  endtask

  task automatic check(string req);
    int ev;
    int evld;
    ev   = alloc_req_i ? exp_victim(int'(alloc_set_i)) : 0;
    evld = alloc_req_i ? 1 : 0;
    n_cmp++;
    if (int'(victim_way_o) != ev || int'(victim_vld_o) != evld) begin
      n_bad++;
      $display("FAIL %s: set=%0d victim=%0d vld=%0d, expected victim=%0d vld=%0d",
               req, alloc_set_i, victim_way_o, victim_vld_o, ev, evld);
    end
  endtask

  task automatic idle();
    flush_i = 0; hit_i = 0; fill_i = 0; inval_i = 0;
    hit_set_i = '0; hit_way_i = '0; fill_set_i = '0; fill_way_i = '0;
    inval_set_i = '0; inval_way_i = '0;
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic step(string req);
    #5;
    check(req);
    @(posedge clk);
    #1;
    if (live != 0) model_update();
    @(negedge clk);
  endtask

  task automatic look(int s, string req);
    idle();
    alloc_req_i = 1; alloc_set_i = SET_W'(s);
    step(req);
  endtask

  task automatic do_fill(int s, int w);
    idle();
    fill_i = 1; fill_set_i = SET_W'(s); fill_way_i = 2'(w);
    step("R5");
  endtask

  task automatic do_hit(int s, int w);
    idle();
    hit_i = 1; hit_set_i = SET_W'(s); hit_way_i = 2'(w);
    step("R4");
  endtask

  task automatic do_inval(int s, int w);
    idle();
    inval_i = 1; inval_set_i = SET_W'(s); inval_way_i = 2'(w);
    step("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (done == 0) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; live = 0; done = 0;
    model_clear();
    idle();
    alloc_req_i = 1; alloc_set_i = SET_W'(5);
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R8: state clear while held in reset
    step("R8");
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1: no request gives zeros
    idle(); alloc_req_i = 0; alloc_set_i = SET_W'(1);
    step("R1");

    // R2: fill set 1 in order and watch the free-way scan
    do_fill(1, 0);
    look(1, "R2");           // expect 1
    do_fill(1, 2);
    look(1, "R2");           // expect 1 (way 1 still free)
    do_fill(1, 1);
    look(1, "R2");           // expect 3
    do_fill(1, 3);
    look(1, "R3");           // full: root0 lo0 -> way 0

    // R4: hit way 0 -> root1, hi0 -> way 2
    do_hit(1, 0);
    look(1, "R4");
    // hit way 2 -> root0, lo1 -> way 1
    do_hit(1, 2);
    look(1, "R4");

    // R9: neighbouring set untouched
    look(2, "R9");

    // R6: invalidate in full set, tree bits kept
    do_inval(1, 2);
    look(1, "R6");           // expect 2
    do_fill(1, 2);
    look(1, "R6");           // tree root0 hi1 lo1 -> way 1
    do_inval(1, 0);
    look(1, "R6");           // expect 0

    // R6: fill and invalidate to one line together
    idle();
    fill_i = 1; fill_set_i = SET_W'(3); fill_way_i = 2'd0;
    inval_i = 1; inval_set_i = SET_W'(3); inval_way_i = 2'd0;
    step("R6");
    look(3, "R6");           // expect 0

    // R5: hit and fill to one set together, fill applied last
    for (int w = 0; w < 4; w++) do_fill(4, w);
    look(4, "R3");           // root0 hi0 lo0 -> way 0
    idle();
    hit_i = 1; hit_set_i = SET_W'(4); hit_way_i = 2'd0;
    fill_i = 1; fill_set_i = SET_W'(4); fill_way_i = 2'd3;
    step("R5");
    look(4, "R5");           // root0 lo1 -> way 1

    // R7: flush with a fill pending in the same cycle
    idle();
    flush_i = 1; fill_i = 1; fill_set_i = SET_W'(4); fill_way_i = 2'd0;
    step("R7");
    look(4, "R7");           // expect 0
    look(1, "R7");           // expect 0
    for (int w = 3; w >= 0; w--) do_fill(1, w);
    look(1, "R7");           // root1 hi1 -> way 3

    // random traffic on a few sets
    for (int i = 0; i < 3000; i++) begin
      idle();
      alloc_req_i = ($urandom % 4) != 0;
      alloc_set_i = SET_W'($urandom % 4);
      flush_i     = ($urandom % 97) == 0;
      hit_i       = ($urandom % 3) == 0;
      hit_set_i   = SET_W'($urandom % 4);
      hit_way_i   = 2'($urandom % 4);
      fill_i      = ($urandom % 3) == 0;
      fill_set_i  = SET_W'($urandom % 4);
      fill_way_i  = 2'($urandom % 4);
      inval_i     = ($urandom % 5) == 0;
      inval_set_i = SET_W'($urandom % 4);
      inval_way_i = 2'($urandom % 4);
      step((exp_victim(int'(alloc_set_i)) < 4 &&
            (mval[alloc_set_i][0] & mval[alloc_set_i][1] &
             mval[alloc_set_i][2] & mval[alloc_set_i][3]) != 0) ? "R3" : "R2");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule